// File: doc/BRIEF.md
# Hash Accelerator Block-Loading Register Front-End

This block is the register-facing half of a SHA-1 / SHA-256 accelerator. Software selects an algorithm and starts a fresh hash through a control register. It then pushes each 512-bit message block as sixteen 32-bit writes and polls a status register. The writes come in two runs of eight. Each run opens with a write to the data port and continues through seven alias ports in ascending order, so a store-multiple instruction can move a whole run to consecutive addresses.

Once the sixteenth word lands, the front-end offers the block, the current chaining state and the mode to a hash core over a valid/ready handshake. It then waits for the core to return the updated chaining state. That returned state is kept in eight digest registers, and software reads the digest words back from them. The chaining state lives in the front-end. On a new-hash command the front-end loads the initial hash values of the selected algorithm. After that, each block carries the previous result to the core.

Top module: `hfe_frontend`

## Requirements
- R1: After reset the STATUS register (word address 1) reads 1: bit 0 WAITING=1, bit 1 DIGEST=0 and bit 2 ERR=0. CTRL (word address 0) reads mode 2, and the digest words read the SHA-256 initial values.
- R2: A CTRL write with mode field bits [1:0] equal to 1 (SHA-1) or 2 (SHA-256) stores the mode. When bit 4 (NEW) is also set, the write clears the word counter, DIGEST and ERR, and loads the initial hash values of that mode into the digest registers.
- R3: A CTRL write with mode value 0 or 3 is ignored, and ERR is set.
- R4: Word k of a block (k = 0..15) must be written to address 2 + (k mod 8). Address 2 is the data port and addresses 3..9 are aliases 0..6. The word appears at bits [32k+31:32k] of blk_words. A data write to any other data-class address is ignored and sets ERR.
- R5: The sixteenth accepted word raises blk_valid and drops WAITING. blk_valid, blk_words, blk_chain and blk_mode hold until blk_ready is seen.
- R6: While WAITING is 0, data writes and CTRL writes are ignored and set ERR.
- R7: A res_valid after the core has accepted the block loads res_chain into the digest registers and sets WAITING and DIGEST. A res_valid at any other time has no effect.
- R8: DIGEST clears on the next accepted data write or on NEW.
- R9: Digest registers sit at word addresses 10..17. In SHA-1 mode, addresses 15..17 read 0. In SHA-256 mode all eight words read the chaining state.
- R10: blk_chain carries the initial values after NEW, and the previous block's result after that.
- R11: ERR is sticky and clears only on a NEW command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write word address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read word address |
| rd_data | output | 32 | Combinational read data |
| blk_valid | output | 1 | Block offered to the core |
| blk_ready | input | 1 | Core takes the block |
| blk_words | output | 512 | Block words, word k at bits [32k+31:32k] |
| blk_chain | output | 256 | Chaining state for this block |
| blk_mode | output | 2 | Algorithm for this block |
| res_valid | input | 1 | Core returns the updated chaining state |
| res_chain | input | 256 | Updated chaining state |

## Verification
Blocks are loaded with four different patterns: incrementing words, all ones, a walking one and a word-indexed constant. Because the patterns differ, a word stored in the wrong lane or a group swapped in blk_words changes the digest the bench predicts. A stub core with a variable ready delay and latency shows that the handshake payload is held and that the chaining state carries correctly from block to block.

Several error cases are driven deliberately: a write to the wrong alias, writes during an outstanding block, an invalid mode and a stray res_valid. Each one is observed at STATUS and at the digest reads, which separates "ignored" from "partly applied". A SHA-1 pass confirms the masking of the upper three digest words.

// File: rtl/hfe_pkg.sv
package hfe_pkg;

    localparam int HFE_WORD_W = 32;
    localparam logic [1:0] MODE_SHA1   = 2'd1;
    localparam logic [1:0] MODE_SHA256 = 2'd2;

    typedef enum logic [1:0] {
        PH_FILL = 2'd0,
        PH_SEND = 2'd1,
        PH_CALC = 2'd2
    } phase_e;

    function automatic logic [HFE_WORD_W-1:0] hfe_iv(input logic [1:0] mode, input int idx);
        logic [HFE_WORD_W-1:0] v;
        v = '0;
        if (mode == MODE_SHA1) begin
            case (idx)
                0: v = 32'h67452301;
                1: v = 32'hEFCDAB89;
                2: v = 32'h98BADCFE;
                3: v = 32'h10325476;
                4: v = 32'hC3D2E1F0;
                default: v = '0;
            endcase
        end else begin
            case (idx)
                0: v = 32'h6A09E667;
                1: v = 32'hBB67AE85;
                2: v = 32'h3C6EF372;
                3: v = 32'hA54FF53A;
                4: v = 32'h510E527F;
                5: v = 32'h9B05688C;
                6: v = 32'h1F83D9AB;
                7: v = 32'h5BE0CD19;
                default: v = '0;
            endcase
        end
        return v;
    endfunction

endpackage

// File: rtl/hfe_word_collect.sv
module hfe_word_collect #(
    parameter int WORD_W    = 32,
    parameter int BLK_WORDS = 16,
    parameter int GRP_WORDS = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          clear_i,
    input  logic                          take_i,
    input  logic [$clog2(GRP_WORDS)-1:0]  slot_i,
    input  logic [WORD_W-1:0]             data_i,
    output logic                          slot_ok_o,
    output logic                          last_o,
    output logic [WORD_W*BLK_WORDS-1:0]   block_o
);
    localparam int BLK_W  = WORD_W * BLK_WORDS;
    localparam int CNT_W  = $clog2(BLK_WORDS);
    localparam int SLOT_W = $clog2(GRP_WORDS);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic [BLK_W-1:0] blk;
    } col_st_t;

    col_st_t st_q, st_d;

    always_comb begin
        st_d      = st_q;
        slot_ok_o = (slot_i == st_q.cnt[SLOT_W-1:0]);
        last_o    = take_i && (st_q.cnt == CNT_W'(BLK_WORDS - 1));
        if (clear_i) begin
            st_d.cnt = '0;
        end else if (take_i) begin
            st_d.blk[st_q.cnt*WORD_W +: WORD_W] = data_i;
            st_d.cnt = last_o ? '0 : st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign block_o = st_q.blk;

    AST_TAKE_IN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |-> slot_ok_o); // R4
    AST_WRAP_AFTER_LAST: assert property (@(posedge clk) disable iff (!rst_n)
        last_o |=> (st_q.cnt == '0)); // R5

endmodule

// File: rtl/hfe_chain_regs.sv
module hfe_chain_regs
    import hfe_pkg::*;
#(
    parameter int WORD_W     = 32,
    parameter int DIG_WORDS  = 8,
    parameter int SHA1_WORDS = 5
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          load_iv_i,
    input  logic [1:0]                    iv_mode_i,
    input  logic                          load_res_i,
    input  logic [WORD_W*DIG_WORDS-1:0]   res_i,
    input  logic [$clog2(DIG_WORDS)-1:0]  rd_idx_i,
    input  logic [1:0]                    rd_mode_i,
    output logic [WORD_W*DIG_WORDS-1:0]   chain_o,
    output logic [WORD_W-1:0]             rd_word_o
);
    localparam int CH_W = WORD_W * DIG_WORDS;

    typedef struct packed {
        logic [CH_W-1:0] chain;
    } ch_st_t;

    ch_st_t st_q, st_d;
    logic [CH_W-1:0] iv_sel;
    logic [CH_W-1:0] iv_rst;

    for (genvar w = 0; w < DIG_WORDS; w++) begin : g_iv
        assign iv_sel[w*WORD_W +: WORD_W] = WORD_W'(hfe_iv(iv_mode_i, w));
        assign iv_rst[w*WORD_W +: WORD_W] = WORD_W'(hfe_iv(MODE_SHA256, w));
    end

    always_comb begin
        st_d = st_q;
        if (load_iv_i) begin
            st_d.chain = iv_sel;
        end else if (load_res_i) begin
            st_d.chain = res_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.chain <= iv_rst;
        end else begin
            st_q <= st_d;
        end
    end

    assign chain_o = st_q.chain;

    always_comb begin
        if ((rd_mode_i == MODE_SHA1) && (int'(rd_idx_i) >= SHA1_WORDS)) begin
            rd_word_o = '0;
        end else begin
            rd_word_o = st_q.chain[rd_idx_i*WORD_W +: WORD_W];
        end
    end

    AST_CHAIN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_iv_i && !load_res_i) |=> $stable(st_q.chain)); // R7
    AST_RES_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_res_i && !load_iv_i) |=> (st_q.chain == $past(res_i))); // R7

endmodule

// File: rtl/hfe_frontend.sv
module hfe_frontend
    import hfe_pkg::*;
#(
    parameter int WORD_W    = HFE_WORD_W,
    parameter int BLK_WORDS = 16,
    parameter int GRP_WORDS = 8,
    parameter int DIG_WORDS = 8,
    parameter int ADDR_W    = 5
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  logic [ADDR_W-1:0]           wr_addr,
    input  logic [WORD_W-1:0]           wr_data,
    input  logic [ADDR_W-1:0]           rd_addr,
    output logic [WORD_W-1:0]           rd_data,
    output logic                        blk_valid,
    input  logic                        blk_ready,
    output logic [WORD_W*BLK_WORDS-1:0] blk_words,
    output logic [WORD_W*DIG_WORDS-1:0] blk_chain,
    output logic [1:0]                  blk_mode,
    input  logic                        res_valid,
    input  logic [WORD_W*DIG_WORDS-1:0] res_chain
);
    localparam int SLOT_W      = $clog2(GRP_WORDS);
    localparam int DIG_IDX_W   = $clog2(DIG_WORDS);
    localparam int A_CTRL      = 0;
    localparam int A_STAT      = 1;
    localparam int A_DATA      = 2;
    localparam int A_DATA_LAST = A_DATA + GRP_WORDS - 1;
    localparam int A_DIG0      = A_DATA + GRP_WORDS;
    localparam int A_DIG_LAST  = A_DIG0 + DIG_WORDS - 1;
    localparam int NEW_BIT     = 4;
    localparam int SHA1_WORDS  = 5;

    typedef struct packed {
        phase_e     phase;
        logic [1:0] mode;
        logic       dig;
        logic       err;
    } fe_st_t;

    fe_st_t st_q, st_d;

    logic                 is_ctrl, is_data, filling, mode_ok;
    logic                 ctrl_ok, new_go, take, err_set;
    logic                 slot_ok, last_word;
    logic [SLOT_W-1:0]    wr_slot;
    logic [DIG_IDX_W-1:0] rd_idx;
    logic [WORD_W-1:0]    dig_word;

    assign wr_slot = SLOT_W'(wr_addr - ADDR_W'(A_DATA));
    assign rd_idx  = DIG_IDX_W'(rd_addr - ADDR_W'(A_DIG0));

    hfe_word_collect #(
        .WORD_W    (WORD_W),
        .BLK_WORDS (BLK_WORDS),
        .GRP_WORDS (GRP_WORDS)
    ) u_collect (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (new_go),
        .take_i    (take),
        .slot_i    (wr_slot),
        .data_i    (wr_data),
        .slot_ok_o (slot_ok),
        .last_o    (last_word),
        .block_o   (blk_words)
    );

    hfe_chain_regs #(
        .WORD_W     (WORD_W),
        .DIG_WORDS  (DIG_WORDS),
        .SHA1_WORDS (SHA1_WORDS)
    ) u_chain (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_iv_i  (new_go),
        .iv_mode_i  (wr_data[1:0]),
        .load_res_i ((st_q.phase == PH_CALC) && res_valid),
        .res_i      (res_chain),
        .rd_idx_i   (rd_idx),
        .rd_mode_i  (st_q.mode),
        .chain_o    (blk_chain),
        .rd_word_o  (dig_word)
    );

    always_comb begin
        is_ctrl = wr_en && (wr_addr == ADDR_W'(A_CTRL));
        is_data = wr_en && (wr_addr >= ADDR_W'(A_DATA)) && (wr_addr <= ADDR_W'(A_DATA_LAST));
        filling = (st_q.phase == PH_FILL);
        mode_ok = (wr_data[1:0] == MODE_SHA1) || (wr_data[1:0] == MODE_SHA256);
        ctrl_ok = is_ctrl && filling && mode_ok;
        new_go  = ctrl_ok && wr_data[NEW_BIT];
        take    = is_data && filling && slot_ok;
        err_set = (is_ctrl && !(filling && mode_ok)) || (is_data && !(filling && slot_ok));

        st_d = st_q;
        if (ctrl_ok) begin
            st_d.mode = wr_data[1:0];
        end
        if (take) begin
            st_d.dig = 1'b0;
        end
        if (new_go) begin
            st_d.dig = 1'b0;
            st_d.err = 1'b0;
        end else if (err_set) begin
            st_d.err = 1'b1;
        end
        case (st_q.phase)
            PH_FILL: if (last_word) st_d.phase = PH_SEND;
            PH_SEND: if (blk_ready) st_d.phase = PH_CALC;
            PH_CALC: if (res_valid) begin
                st_d.phase = PH_FILL;
                st_d.dig   = 1'b1;
            end
            default: st_d.phase = PH_FILL;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase <= PH_FILL;
            st_q.mode  <= MODE_SHA256;
            st_q.dig   <= 1'b0;
            st_q.err   <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign blk_valid = (st_q.phase == PH_SEND);
    assign blk_mode  = st_q.mode;

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADDR_W'(A_CTRL)) begin
            rd_data[1:0] = st_q.mode;
        end else if (rd_addr == ADDR_W'(A_STAT)) begin
            rd_data[0] = filling;
            rd_data[1] = st_q.dig;
            rd_data[2] = st_q.err;
        end else if ((rd_addr >= ADDR_W'(A_DIG0)) && (rd_addr <= ADDR_W'(A_DIG_LAST))) begin
            rd_data = dig_word;
        end
    end

    AST_VALID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (blk_valid && !blk_ready) |=> (blk_valid && $stable(blk_words) && $stable(blk_chain))); // R5
    AST_BUSY_WRITE_ERR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (wr_addr == ADDR_W'(A_DATA)) && blk_valid) |=> st_q.err); // R6
    AST_BAD_MODE: assert property (@(posedge clk) disable iff (!rst_n)
        (is_ctrl && filling && !mode_ok) |=> (st_q.err && $stable(st_q.mode))); // R3
    AST_DIG_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !st_q.dig); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.err && !new_go) |=> st_q.err); // R11
    AST_RESULT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.phase == PH_CALC) && res_valid) |=> (st_q.dig && (st_q.phase == PH_FILL))); // R7

endmodule

// File: tb/hfe_frontend_tb.sv
module hfe_frontend_tb_top;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         wr_en = 1'b0;
    logic [4:0]   wr_addr = '0;
    logic [31:0]  wr_data = '0;
    logic [4:0]   rd_addr = 5'd1;
    logic [31:0]  rd_data;
    logic         blk_valid;
    logic         blk_ready = 1'b0;
    logic [511:0] blk_words;
    logic [255:0] blk_chain;
    logic [1:0]   blk_mode;
    logic         res_valid = 1'b0;
    logic [255:0] res_chain = '0;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    hfe_frontend dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .blk_valid (blk_valid),
        .blk_ready (blk_ready),
        .blk_words (blk_words),
        .blk_chain (blk_chain),
        .blk_mode  (blk_mode),
        .res_valid (res_valid),
        .res_chain (res_chain)
    );

    logic [31:0] iv1   [5] = '{32'h67452301, 32'hEFCDAB89, 32'h98BADCFE, 32'h10325476, 32'hC3D2E1F0};
    logic [31:0] iv256 [8] = '{32'h6A09E667, 32'hBB67AE85, 32'h3C6EF372, 32'hA54FF53A,
                               32'h510E527F, 32'h9B05688C, 32'h1F83D9AB, 32'h5BE0CD19};

    // ---------------- reference model ----------------
    int          m_phase;
    logic [1:0]  m_mode;
    logic        m_dig, m_err;
    int          m_cnt;
    logic [31:0] m_words [16];
    logic [31:0] m_chain [8];

    function automatic logic [31:0] iv_of(input logic [1:0] md, input int i);
        if (md == 2'd1) return (i < 5) ? iv1[i] : 32'h0;
        return iv256[i];
    endfunction

    task automatic model_reset();
        m_phase = 0; m_mode = 2'd2; m_dig = 0; m_err = 0; m_cnt = 0;
        for (int i = 0; i < 8; i++) m_chain[i] = iv256[i];
    endtask

    task automatic model_step();
        int ph0;
        bit werr;
        ph0  = m_phase;
        werr = 0;
        if (wr_en) begin
            if (wr_addr == 5'd0) begin
                if (ph0 != 0 || !(wr_data[1:0] == 2'd1 || wr_data[1:0] == 2'd2)) werr = 1;
                else begin
                    m_mode = wr_data[1:0];
                    if (wr_data[4]) begin
                        m_cnt = 0; m_dig = 0; m_err = 0;
                        for (int i = 0; i < 8; i++) m_chain[i] = iv_of(m_mode, i);
                    end
                end
            end else if (wr_addr >= 5'd2 && wr_addr <= 5'd9) begin
                if (ph0 != 0 || (int'(wr_addr) - 2) != (m_cnt % 8)) werr = 1;
                else begin
                    m_words[m_cnt] = wr_data;
                    m_dig = 0;
                    if (m_cnt == 15) begin m_cnt = 0; m_phase = 1; end
                    else m_cnt++;
                end
            end
        end
        if (werr) m_err = 1;
        if (ph0 == 1 && blk_ready) m_phase = 2;
        else if (ph0 == 2 && res_valid) begin
            m_phase = 0;
            m_dig   = 1;
            for (int i = 0; i < 8; i++) m_chain[i] = res_chain[i*32 +: 32];
        end
    endtask

    function automatic logic [31:0] model_read(input logic [4:0] a);
        if (a == 5'd0) return {30'b0, m_mode};
        if (a == 5'd1) return {29'b0, m_err, m_dig, (m_phase == 0)};
        if (a >= 5'd10 && a <= 5'd17) begin
            if (m_mode == 2'd1 && (int'(a) - 10) >= 5) return 32'h0;
            return m_chain[int'(a) - 10];
        end
        return 32'h0;
    endfunction

    function automatic string tag_of(input logic [4:0] a);
        if (a == 5'd0) return "R2";
        if (a == 5'd1) return "R11";
        if (a >= 5'd10) return "R9";
        return "R1";
    endfunction

    // per-clock comparison against the model
    always @(posedge clk) begin
        if (!rst_n) model_reset();
        else model_step();
        #1;
        if (rst_n) begin
            logic [511:0] mw;
            logic [255:0] mc;
            logic [31:0]  er;
            for (int i = 0; i < 16; i++) mw[i*32 +: 32] = m_words[i];
            for (int i = 0; i < 8; i++)  mc[i*32 +: 32] = m_chain[i];
            checks++;
            if (blk_valid !== (m_phase == 1)) begin
                errors++;
                $display("FAIL R5 blk_valid act=%0b exp=%0b", blk_valid, (m_phase == 1));
            end
            if (m_phase == 1) begin
                checks += 3;
                if (blk_words !== mw) begin
                    errors++;
                    $display("FAIL R4 blk_words act=%h exp=%h", blk_words, mw);
                end
                if (blk_chain !== mc) begin
                    errors++;
                    $display("FAIL R10 blk_chain act=%h exp=%h", blk_chain, mc);
                end
                if (blk_mode !== m_mode) begin
                    errors++;
                    $display("FAIL R2 blk_mode act=%0d exp=%0d", blk_mode, m_mode);
                end
            end
            er = model_read(rd_addr);
            checks++;
            if (rd_data !== er) begin
                errors++;
                $display("FAIL %s rd[%0d] act=%h exp=%h", tag_of(rd_addr), rd_addr, rd_data, er);
            end
        end
    end

    // ---------------- stimulus helpers ----------------
    logic [31:0]  blkw [16];
    logic [255:0] ex_chain;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] d);
        @(negedge clk);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic send_block();
        for (int i = 0; i < 16; i++) wr(5'(2 + (i % 8)), blkw[i]);
    endtask

    function automatic logic [255:0] stub_f(input logic [511:0] w, input logic [255:0] c);
        logic [255:0] r;
        for (int i = 0; i < 8; i++) begin
            logic [31:0] x, y;
            x = w[(i+8)*32 +: 32];
            y = (x << (i + 1)) | (x >> (31 - i));
            r[i*32 +: 32] = c[i*32 +: 32] + (w[i*32 +: 32] ^ y) + 32'(i);
        end
        return r;
    endfunction

    function automatic logic [511:0] pack_blk();
        logic [511:0] p;
        for (int i = 0; i < 16; i++) p[i*32 +: 32] = blkw[i];
        return p;
    endfunction

    // stub core: accept after dly cycles, answer after lat cycles
    task automatic serve(input int dly, input int lat);
        logic [511:0] cw;
        logic [255:0] cc;
        repeat (dly) @(negedge clk);
        @(negedge clk);
        cw = blk_words; cc = blk_chain;
        blk_ready = 1'b1;
        @(negedge clk);
        blk_ready = 1'b0;
        repeat (lat) @(negedge clk);
        res_chain = stub_f(cw, cc);
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic check_digest(input string tag, input logic [1:0] md);
        logic [31:0] v;
        for (int k = 0; k < 8; k++) begin
            rd(5'(10 + k), v);
            if (md == 2'd1 && k >= 5) chk(tag, v, 32'h0);
            else chk(tag, v, ex_chain[k*32 +: 32]);
        end
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(5'd1, v); chk("R1 status", v, 32'h1);
        rd(5'd0, v); chk("R1 ctrl", v, 32'h2);
        for (int i = 0; i < 8; i++) ex_chain[i*32 +: 32] = iv256[i];
        check_digest("R1 digest", 2'd2);

        // R2 NEW SHA-256, incrementing block; R5 handshake
        wr(5'd0, 32'h12);
        for (int i = 0; i < 16; i++) blkw[i] = 32'h01010101 * (i + 1);
        send_block();
        rd(5'd1, v); chk("R5 waiting low", v, 32'h0);
        chk("R5 blk_valid", {31'b0, blk_valid}, 32'h1);
        serve(3, 4);
        ex_chain = stub_f(pack_blk(), ex_chain);
        rd(5'd1, v); chk("R7 status done", v, 32'h3);
        check_digest("R7 R10 digest A", 2'd2);

        // R6 writes while busy; all-ones block
        for (int i = 0; i < 16; i++) blkw[i] = 32'hFFFFFFFF;
        send_block();
        wr(5'd2, 32'hDEADBEEF);
        wr(5'd0, 32'h11);
        rd(5'd0, v); chk("R6 ctrl ignored", v, 32'h2);
        rd(5'd1, v); chk("R6 err set", v, 32'h4);
        serve(0, 1);
        ex_chain = stub_f(pack_blk(), ex_chain);
        check_digest("R10 digest B", 2'd2);
        rd(5'd1, v); chk("R11 err sticky", v, 32'h7);

        // R8 digest clears on data write
        wr(5'd2, 32'h5);
        rd(5'd1, v); chk("R8 digest cleared", v, 32'h5);

        // R2 R11 NEW clears err and counter
        wr(5'd0, 32'h12);
        rd(5'd1, v); chk("R11 cleared by NEW", v, 32'h1);
        for (int i = 0; i < 8; i++) ex_chain[i*32 +: 32] = iv256[i];

        // R4 out of order write; walking-one block
        wr(5'd3, 32'h12345678);
        rd(5'd1, v); chk("R4 wrong alias err", v, 32'h5);
        for (int i = 0; i < 16; i++) blkw[i] = 32'h1 << (i * 2);
        send_block();
        serve(5, 0);
        ex_chain = stub_f(pack_blk(), ex_chain);
        check_digest("R4 digest C", 2'd2);

        // R3 invalid mode
        wr(5'd0, 32'h13);
        rd(5'd0, v); chk("R3 mode kept", v, 32'h2);
        wr(5'd0, 32'h10);
        rd(5'd0, v); chk("R3 mode0 kept", v, 32'h2);
        rd(5'd1, v); chk("R3 err", v, 32'h7);

        // R8 NEW clears DIGEST; R9 SHA-1
        wr(5'd0, 32'h11);
        rd(5'd1, v); chk("R8 NEW clears digest", v, 32'h1);
        rd(5'd0, v); chk("R2 sha1 mode", v, 32'h1);
        for (int i = 0; i < 8; i++) ex_chain[i*32 +: 32] = iv_of(2'd1, i);
        check_digest("R9 sha1 iv", 2'd1);
        for (int i = 0; i < 16; i++) blkw[i] = 32'hA5A50000 | 32'(i);
        send_block();
        chk("R2 blk_mode sha1", {30'b0, blk_mode}, 32'h1);
        serve(2, 2);
        ex_chain = stub_f(pack_blk(), ex_chain);
        check_digest("R9 sha1 digest", 2'd1);

        // R7 stray result ignored
        @(negedge clk);
        res_chain = '1; res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
        check_digest("R7 stray ignored", 2'd1);
        rd(5'd1, v); chk("R7 stray status", v, 32'h3);

        repeat (4) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule